// File: doc/BRIEF.md
# Receive Frame Queue with Length-Prefixed Word Readout

This block sits between a byte-wide receive stream and a processor. Incoming frames, delimited by start and end markers, are captured into a ring of packet slots. Each stored packet is presented to software as a self-describing byte image: a two-byte length header first, then the frame bytes, then a four-byte checksum taken from an input that is valid with the last frame byte, then zero bytes up to the next word boundary.

Software drains the queue through one 32-bit data select. Every data read returns the next four bytes of the image at the head of the ring. After the last word of a packet the head moves to the next slot and the packet count goes down by one, so the next read starts with the next packet's header. A count select reports how many packets are waiting. A control select holds the receive enable and a flush action. A status bit, which also drives the interrupt output, records that a packet was stored.

Top module: `rx_frame_queue`

## Requirements
- R1: After reset the packet count is 0, the status bit and the interrupt output are 0, the receive enable is 0, and a data read returns 0.
- R2: A frame whose start byte arrives while the receive enable (control select 1, bit 0) is 0 is not stored, and the count does not change.
- R3: A frame whose start byte arrives while SLOTS (default 31) packets are queued is not stored. The count never exceeds SLOTS.
- R4: The first word read from a packet has bits 15:0 equal to the frame byte count plus 6, low byte in bits 7:0.
- R5: The frame bytes follow the header in arrival order, and each data read (select 2) places the earliest byte in bits 7:0.
- R6: The four checksum bytes follow the frame bytes, least significant byte first.
- R7: Bytes after the checksum, up to the next multiple of four, read as zero.
- R8: When a read brings the bytes left in a packet to zero or below, the count drops by one and the head slot advances, wrapping from SLOTS-1 to 0, so packets come out in arrival order.
- R9: Writing control select 1 with bit 1 set empties the queue, drops any partly read packet and any frame being captured, and loads bit 0 into the enable.
- R10: Storing a packet sets status bit 0 (select 0) and the interrupt output. Writing 1 to that bit clears it, and a store in the same cycle as the clear leaves it set.
- R11: A read of select 3 returns the packet count, and writes to select 3 change nothing.
- R12: A data read with no packet queued and none partly read returns 0 and changes no state.
- R13: A frame of more than SLOT_BYTES-6 bytes (58 by default) is dropped whole.
- R14: A packet store and the read that finishes the head packet may fall in the same cycle, and the count is then unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | The byte is the first of a frame |
| rx_eof | input | 1 | The byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| rx_fcs | input | 32 | Frame checksum, sampled with the last byte |
| reg_sel | input | 2 | Register select: 0 status, 1 control, 2 data, 3 count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; on select 2 it pops a word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from select and state |
| irq | output | 1 | Packet-stored interrupt, equal to status bit 0 |

## Verification
Two pairs of events can fall in one cycle: a frame's last byte, which stores a packet, and the data read that finishes the head packet, which removes one; and the same store against a software clear of the status bit. The bench provokes both by raising the read or write strobe on the exact cycle that carries the end-of-frame byte. A behavioural model of queues and byte lists predicts the count, the interrupt and every word. The result is judged by the interrupt, which is compared on every clock, and by the count and word reads that follow.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_DATA   = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_FLUSH_BIT = 1;
    localparam int STAT_RX_BIT    = 0;

    localparam int HDR_BYTES = 2;
    localparam int FCS_BYTES = 4;
    localparam int OVERHEAD  = HDR_BYTES + FCS_BYTES;

    // Per-slot metadata: stored length (frame bytes + OVERHEAD) and checksum
    typedef struct packed {
        logic [15:0] len;
        logic [31:0] fcs;
    } slot_meta_t;

endpackage

// File: rtl/rxq_capture.sv
module rxq_capture
    import rxq_pkg::*;
#(
    parameter int SLOTS   = 31,
    parameter int PAY_CAP = 58,
    parameter int SW      = 5,
    parameter int IW      = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic [7:0]    rx_data,
    input  logic [31:0]   rx_fcs,
    input  logic          enable,
    input  logic          space_ok,
    input  logic          flush,
    input  logic [SW-1:0] start_slot,
    output logic          wr_en,
    output logic [SW-1:0] wr_slot,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_byte,
    output logic          commit,
    output logic [SW-1:0] commit_slot,
    output slot_meta_t    commit_meta
);

    logic          busy_q;
    logic          too_long_q;
    logic [SW-1:0] slot_q;
    logic [IW-1:0] cnt_q;

    logic          take;
    logic [IW-1:0] idx;
    logic          in_cap;

    always_comb begin
        take   = rx_valid && !flush && (rx_sof ? (enable && space_ok) : busy_q);
        idx    = rx_sof ? '0 : cnt_q;
        in_cap = idx < IW'(PAY_CAP);
    end

    assign wr_slot     = rx_sof ? start_slot : slot_q;
    assign wr_en       = take && in_cap;
    assign wr_idx      = idx;
    assign wr_byte     = rx_data;
    assign commit      = take && rx_eof && in_cap && (rx_sof || !too_long_q);
    assign commit_slot = wr_slot;

    always_comb begin
        commit_meta.len = idx + IW'(1 + OVERHEAD);
        commit_meta.fcs = rx_fcs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            too_long_q <= 1'b0;
            slot_q     <= '0;
            cnt_q      <= '0;
        end else if (flush) begin
            busy_q <= 1'b0;
        end else if (rx_valid) begin
            if (rx_sof) begin
                busy_q     <= take && !rx_eof;
                slot_q     <= start_slot;
                cnt_q      <= IW'(1);
                too_long_q <= 1'b0;
            end else if (busy_q) begin
                cnt_q <= (cnt_q == '1) ? cnt_q : cnt_q + IW'(1);
                if (!in_cap) too_long_q <= 1'b1;
                if (rx_eof) busy_q <= 1'b0;
            end
        end
    end

    // R2: outside a frame only a start byte can lead to a store
    a_r2_no_stray_store: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !(rx_valid && rx_sof)) |-> !commit);

    // R13: a stored length never exceeds the slot capacity
    a_r13_len_fits: assert property (@(posedge clk) disable iff (rst)
        commit |-> (commit_meta.len <= IW'(PAY_CAP + OVERHEAD)));

endmodule

// File: rtl/rxq_slot_mem.sv
module rxq_slot_mem
    import rxq_pkg::*;
#(
    parameter int SLOTS   = 31,
    parameter int PAY_CAP = 58,
    parameter int SW      = 5,
    parameter int IW      = 16
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic          commit,
    input  logic [SW-1:0] commit_slot,
    input  slot_meta_t    commit_meta,
    input  logic [SW-1:0] rd_slot,
    input  logic [IW-1:0] rd_off,
    output logic [15:0]   rd_len,
    output logic [31:0]   rd_word
);

    localparam int DEPTH = SLOTS * PAY_CAP;
    localparam int AW    = $clog2(DEPTH);

    logic [7:0]  pay  [DEPTH];
    slot_meta_t  meta [SLOTS];

    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_base;
    slot_meta_t    cur;
    logic [IW-1:0] pay_n;

    assign wr_addr = AW'(wr_slot) * AW'(PAY_CAP) + AW'(wr_idx);
    assign rd_base = AW'(rd_slot) * AW'(PAY_CAP);
    assign cur     = meta[rd_slot];
    assign rd_len  = cur.len;
    assign pay_n   = cur.len - IW'(OVERHEAD);

    always_ff @(posedge clk) begin
        if (wr_en)  pay[wr_addr]       <= wr_byte;
        if (commit) meta[commit_slot]  <= commit_meta;
    end

    // Header, payload, checksum and padding are assembled per byte lane
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [IW-1:0] k;
        logic [IW-1:0] p;
        logic [IW-1:0] q;
        logic [7:0]    lane;
        always_comb begin
            k    = rd_off + IW'(g);
            p    = k - IW'(HDR_BYTES);
            q    = p - pay_n;
            lane = 8'h00;
            if (k == IW'(0))
                lane = cur.len[7:0];
            else if (k == IW'(1))
                lane = cur.len[15:8];
            else if (p < pay_n)
                lane = pay[rd_base + AW'(p)];
            else if (q < IW'(FCS_BYTES))
                lane = cur.fcs[{q[1:0], 3'b000} +: 8];
        end
        assign rd_word[8*g +: 8] = lane;
    end

endmodule

// File: rtl/rxq_pop_ctrl.sv
module rxq_pop_ctrl
    import rxq_pkg::*;
#(
    parameter int SLOTS = 31,
    parameter int SW    = 5,
    parameter int IW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pop,
    input  logic          flush,
    input  logic          have_pkt,
    input  logic [15:0]   head_len,
    output logic [SW-1:0] head,
    output logic [IW-1:0] rd_off,
    output logic          empty_read,
    output logic          advance
);

    logic          active_q;
    logic [IW-1:0] off_q;
    logic [IW:0]   rem_q;
    logic [IW:0]   cur_rem;
    logic [IW:0]   nxt_rem;
    logic          done;

    always_comb begin
        cur_rem    = active_q ? rem_q : {1'b0, head_len};
        nxt_rem    = cur_rem - (IW+1)'(4);
        done       = nxt_rem[IW] || (nxt_rem == '0);
        empty_read = !active_q && !have_pkt;
        advance    = pop && !empty_read && done;
        rd_off     = active_q ? off_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            off_q    <= '0;
            rem_q    <= '0;
            head     <= '0;
        end else if (flush) begin
            active_q <= 1'b0;
            off_q    <= '0;
        end else if (pop && !empty_read) begin
            if (done) begin
                active_q <= 1'b0;
                off_q    <= '0;
                head     <= (head == SW'(SLOTS - 1)) ? '0 : head + SW'(1);
            end else begin
                active_q <= 1'b1;
                off_q    <= rd_off + IW'(4);
                rem_q    <= nxt_rem;
            end
        end
    end

    // R12: a read of an empty queue moves nothing
    a_r12_empty_hold: assert property (@(posedge clk) disable iff (rst)
        (pop && empty_read && !flush) |=> ($stable(head) && !active_q));

    // R8: the head wraps from the last slot to slot 0
    a_r8_head_wrap: assert property (@(posedge clk) disable iff (rst)
        (advance && !flush && head == SW'(SLOTS - 1)) |=> (head == '0));

endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
    import rxq_pkg::*;
#(
    parameter int SLOTS      = 31,
    parameter int SLOT_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_data,
    input  logic [31:0] rx_fcs,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);

    localparam int PAY_CAP = SLOT_BYTES - OVERHEAD;
    localparam int SW      = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CW      = $clog2(SLOTS + 1);
    localparam int IW      = 16;
    localparam int SUMW    = ((SW > CW) ? SW : CW) + 1;

    reg_sel_e      sel;
    logic [CW-1:0] count_q;
    logic          en_q;
    logic          stat_q;

    logic          flush, pop, have_pkt, space_ok;
    logic [SUMW-1:0] slot_sum;
    logic [SW-1:0] start_slot;

    logic          wr_en, commit;
    logic [SW-1:0] wr_slot, commit_slot, head;
    logic [IW-1:0] wr_idx, rd_off;
    logic [7:0]    wr_byte;
    slot_meta_t    commit_meta;
    logic [15:0]   head_len;
    logic [31:0]   rd_word;
    logic          empty_read, advance;
    logic          unused_wdata;

    assign sel          = reg_sel_e'(reg_sel);
    assign flush        = reg_wr && (sel == SEL_CTRL) && reg_wdata[CTRL_FLUSH_BIT];
    assign pop          = reg_rd && (sel == SEL_DATA);
    assign have_pkt     = (count_q != '0);
    assign space_ok     = (count_q < CW'(SLOTS));
    assign slot_sum     = SUMW'(head) + SUMW'(count_q);
    assign start_slot   = (slot_sum >= SUMW'(SLOTS)) ? SW'(slot_sum - SUMW'(SLOTS))
                                                     : SW'(slot_sum);
    assign unused_wdata = ^reg_wdata[31:2];

    rxq_capture #(.SLOTS(SLOTS), .PAY_CAP(PAY_CAP), .SW(SW), .IW(IW)) u_cap (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .rx_fcs(rx_fcs),
        .enable(en_q), .space_ok(space_ok), .flush(flush), .start_slot(start_slot),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_byte(wr_byte),
        .commit(commit), .commit_slot(commit_slot), .commit_meta(commit_meta)
    );

    rxq_slot_mem #(.SLOTS(SLOTS), .PAY_CAP(PAY_CAP), .SW(SW), .IW(IW)) u_mem (
        .clk(clk),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_byte(wr_byte),
        .commit(commit), .commit_slot(commit_slot), .commit_meta(commit_meta),
        .rd_slot(head), .rd_off(rd_off), .rd_len(head_len), .rd_word(rd_word)
    );

    rxq_pop_ctrl #(.SLOTS(SLOTS), .SW(SW), .IW(IW)) u_pop (
        .clk(clk), .rst(rst),
        .pop(pop), .flush(flush), .have_pkt(have_pkt), .head_len(head_len),
        .head(head), .rd_off(rd_off), .empty_read(empty_read), .advance(advance)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            en_q    <= 1'b0;
            stat_q  <= 1'b0;
        end else begin
            if (flush)
                count_q <= '0;
            else if (commit && !advance)
                count_q <= count_q + CW'(1);
            else if (advance && !commit)
                count_q <= count_q - CW'(1);

            if (reg_wr && sel == SEL_CTRL)
                en_q <= reg_wdata[CTRL_EN_BIT];

            if (commit)
                stat_q <= 1'b1;
            else if (reg_wr && sel == SEL_STATUS && reg_wdata[STAT_RX_BIT])
                stat_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = {31'd0, stat_q};
            SEL_CTRL:   reg_rdata = {31'd0, en_q};
            SEL_DATA:   reg_rdata = empty_read ? 32'd0 : rd_word;
            SEL_COUNT:  reg_rdata = 32'(count_q);
        endcase
    end

    assign irq = stat_q;

    // R3: the count stays within the slot total
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(SLOTS));

    // R8: finishing the head packet alone lowers the count by one
    a_r8_count_drop: assert property (@(posedge clk) disable iff (rst)
        (advance && !commit && !flush) |=> (count_q == $past(count_q) - CW'(1)));

    // R9: a flush leaves the queue empty
    a_r9_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count_q == '0));

    // R10: a store raises the interrupt on the next cycle
    a_r10_irq_on_store: assert property (@(posedge clk) disable iff (rst)
        commit |=> irq);

    // R14: a store and a finishing read together keep the count
    a_r14_net_hold: assert property (@(posedge clk) disable iff (rst)
        (commit && advance && !flush) |=> $stable(count_q));

endmodule

// File: tb/sim_rx_frame_queue.sv
`timescale 1ns/1ps
module sim_rx_frame_queue;

    localparam int SLOTS   = 31;
    localparam int PAY_CAP = 58;
    localparam int MAXCYC  = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 0, rx_sof = 0, rx_eof = 0;
    logic [7:0]  rx_data = 0;
    logic [31:0] rx_fcs = 0;
    logic [1:0]  reg_sel = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0] m_img[$];
    int         m_plen[$];
    int         m_pos = 0;
    logic [7:0] m_cur[$];
    bit         m_busy = 0;
    bit         en_m = 0;
    bit         irq_m = 0;

    always #10 clk = ~clk;

    rx_frame_queue u0 (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .rx_fcs(rx_fcs),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_pop(output logic [31:0] w);
        if (m_plen.size() == 0) begin
            w = 32'd0;
        end else begin
            w = {m_img[3], m_img[2], m_img[1], m_img[0]};
            for (int i = 0; i < 4; i++) void'(m_img.pop_front());
            m_pos += 4;
            if (m_pos >= m_plen[0]) begin
                void'(m_plen.pop_front());
                m_pos = 0;
            end
        end
    endtask

    task automatic model_store(logic [31:0] fcs);
        int len;
        int sz;
        len = m_cur.size() + 6;
        m_img.push_back(len[7:0]);
        m_img.push_back(len[15:8]);
        foreach (m_cur[i]) m_img.push_back(m_cur[i]);
        for (int i = 0; i < 4; i++) m_img.push_back(fcs[8*i +: 8]);
        sz = len;
        while (sz % 4 != 0) begin
            m_img.push_back(8'h00);
            sz++;
        end
        m_plen.push_back(sz);
        irq_m = 1;
    endtask

    // one clock: check reads, advance the model, step, compare the interrupt
    task automatic tick(string tag);
        logic [31:0] exp;
        int  size0;
        bit  flush_now;
        bit  store;
        #1;
        size0     = m_plen.size();
        flush_now = reg_wr && reg_sel == 2'd1 && reg_wdata[1];
        store     = 0;
        if (reg_rd) begin
            case (reg_sel)
                2'd0: exp = {31'd0, irq_m};
                2'd1: exp = {31'd0, en_m};
                2'd2: model_pop(exp);
                default: exp = size0;
            endcase
            check(tag, reg_rdata, exp);
        end
        if (rx_valid && !flush_now) begin
            if (rx_sof) begin
                m_busy = en_m && (size0 < SLOTS);
                m_cur.delete();
            end
            if (m_busy) m_cur.push_back(rx_data);
            if (rx_eof && m_busy) begin
                m_busy = 0;
                if (m_cur.size() <= PAY_CAP) store = 1;
            end
        end
        if (flush_now) begin
            m_busy = 0;
            m_img.delete();
            m_plen.delete();
            m_pos = 0;
        end
        if (reg_wr && reg_sel == 2'd1) en_m = reg_wdata[0];
        if (reg_wr && reg_sel == 2'd0 && reg_wdata[0]) irq_m = 0;
        if (store) model_store(rx_fcs);
        @(posedge clk);
        @(negedge clk);
        check("R10 irq", {31'd0, irq}, {31'd0, irq_m});
    endtask

    task automatic rd(logic [1:0] s, string tag);
        reg_sel = s; reg_rd = 1;
        tick(tag);
        reg_rd = 0;
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d, string tag);
        reg_sel = s; reg_wdata = d; reg_wr = 1;
        tick(tag);
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic send(int n, logic [31:0] fcs, logic [7:0] base, bit pop_last, bit clr_last);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n - 1);
            rx_data = base + 8'(i); rx_fcs = fcs;
            if (i == n - 1 && pop_last) begin reg_sel = 2'd2; reg_rd = 1; end
            if (i == n - 1 && clr_last) begin reg_sel = 2'd0; reg_wdata = 1; reg_wr = 1; end
            tick(pop_last ? "R14 pop on store" : "R5 capture");
            reg_rd = 0; reg_wr = 0; reg_wdata = 0;
        end
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
    endtask

    task automatic read_pkt(int n);
        int w;
        w = (n + 6 + 3) / 4;
        for (int i = 0; i < w; i++)
            rd(2'd2, (i == 0) ? "R4 header" : ((i == w - 1) ? "R6 R7 R8 tail" : "R5 body"));
    endtask

    initial begin
        #(MAXCYC * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 / R12: reset state and empty reads
        rd(2'd3, "R1 count");
        rd(2'd0, "R1 status");
        rd(2'd1, "R1 enable");
        rd(2'd2, "R1 R12 empty data");
        rd(2'd2, "R12 empty data");
        rd(2'd3, "R12 count");

        // R2: receive disabled
        send(4, 32'h11223344, 8'h40, 0, 0);
        rd(2'd3, "R2 count");

        // R4-R8: several lengths, each pad case
        wr(2'd1, 32'h1, "R9 enable");
        for (int n = 1; n <= 6; n++)
            send(n, 32'hA1B2C300 + n, 8'(16 * n), 0, 0);
        rd(2'd3, "R8 count");
        for (int n = 1; n <= 6; n++) read_pkt(n);
        rd(2'd3, "R8 count drained");
        wr(2'd0, 32'h1, "R10 clear");
        rd(2'd0, "R10 status");

        // R3: fill, overflow, drain with head wrap
        for (int i = 0; i < SLOTS + 1; i++)
            send(2, 32'hC0DE0000 + i, 8'(i), 0, 0);
        rd(2'd3, "R3 count full");
        for (int i = 0; i < SLOTS; i++) read_pkt(2);
        rd(2'd3, "R8 count after wrap");

        // R13: capacity limit
        send(PAY_CAP, 32'h5A5A0001, 8'h80, 0, 0);
        send(PAY_CAP + 1, 32'h5A5A0002, 8'h90, 0, 0);
        send(70, 32'h5A5A0003, 8'hA0, 0, 0);
        rd(2'd3, "R13 count");
        read_pkt(PAY_CAP);

        // R9: flush during a partial read
        send(10, 32'h0F0F0F0F, 8'h01, 0, 0);
        send(10, 32'hF0F0F0F0, 8'h31, 0, 0);
        rd(2'd2, "R4 header");
        wr(2'd1, 32'h3, "R9 flush");
        rd(2'd3, "R9 count");
        rd(2'd2, "R9 R12 empty after flush");
        send(3, 32'h01020304, 8'hE0, 0, 0);
        read_pkt(3);

        // R11: count select ignores writes
        send(2, 32'hDEADBEEF, 8'h70, 0, 0);
        wr(2'd3, 32'h1F, "R11 write");
        rd(2'd3, "R11 count");
        read_pkt(2);

        // R14: store and finishing read in the same cycle
        send(2, 32'h12345678, 8'h55, 0, 0);
        rd(2'd2, "R4 header");
        send(3, 32'h87654321, 8'h66, 1, 0);
        rd(2'd3, "R14 count");
        read_pkt(3);
        rd(2'd3, "R14 count drained");

        // R10: store wins over a simultaneous clear
        wr(2'd0, 32'h1, "R10 clear");
        send(2, 32'hCAFEF00D, 8'h77, 0, 1);
        rd(2'd0, "R10 set wins");
        read_pkt(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule